// File: doc/BRIEF.md
# Sequential Restoring Unsigned Divider

This block divides an unsigned dividend of 2N bits by an unsigned divisor of N bits and returns an N-bit quotient and an N-bit remainder. It runs over several clock cycles and settles one quotient bit per cycle. A single working register holds the partial remainder in its upper half. The quotient bits collect in its lower half as the register shifts left. The arithmetic unit is only N bits wide, plus one carry bit that keeps the bit shifted out of the upper half. Each step subtracts the divisor from the upper half and either keeps the difference or keeps the old value (the restore). It then shifts in a quotient bit of 1 or 0.

The caller raises `start` for one cycle while the block is idle. The operands are loaded into the working register and shifted left by one bit. N subtract/restore steps follow, and then a correction cycle shifts the upper half right by one bit to form the remainder. Two operand cases finish at once without running the steps: a zero divisor, and an upper dividend half that is already at least the divisor, which means the quotient does not fit in N bits. Each of these raises its own flag and returns saturated outputs. Results stay on the outputs until the next operation completes.

Top module: `div_restoring`

## Requirements
- R1: A `start` seen while `busy` is low, with a nonzero divisor and dividend[2N-1:N] below the divisor, drives `busy` high from the next cycle for exactly N+1 cycles.
- R2: `done` is high for exactly one cycle. For a running division this is the cycle in which `busy` has just fallen, N+2 cycles after the cycle in which `start` was sampled.
- R3: For a running division, `quotient` equals floor(dividend/divisor) and `remainder` equals dividend mod divisor in the `done` cycle.
- R4: With N=8, dividend 250 and divisor 10 give quotient 25 and remainder 0.
- R5: A zero divisor at an accepted `start` sets `div_by_zero`=1, `overflow`=0, `quotient`=all ones and `remainder`=dividend[N-1:0]. `done` is high in the next cycle and `busy` stays low.
- R6: A nonzero divisor with dividend[2N-1:N] >= divisor at an accepted `start` sets `overflow`=1, `div_by_zero`=0, `quotient`=all ones and `remainder`=dividend[N-1:0]. `done` is high in the next cycle and `busy` stays low.
- R7: A running division clears both flags, in the same cycle that its result appears.
- R8: `start` while `busy` is high is ignored: the running operation's timing and result do not change.
- R9: `quotient`, `remainder` and both flags change only in a `done` cycle. They hold their values whatever the inputs do in between.
- R10: After synchronous reset, `busy`, `done`, `quotient`, `remainder`, `div_by_zero` and `overflow` are all 0.
- R11: Results are correct when the left shift of the upper half carries out of N bits, for example 0xFEFF / 0xFF gives 255 remainder 254.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation (used only while idle) |
| dividend | input | 2N | Unsigned dividend |
| divisor | input | N | Unsigned divisor |
| busy | output | 1 | Division steps in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | N | Quotient result |
| remainder | output | N | Remainder result |
| div_by_zero | output | 1 | Last result came from a zero divisor |
| overflow | output | 1 | Last result came from a quotient too wide for N bits |

## Verification
A running division returns its result N+2 cycles after the edge that samples `start`. Zero-divisor and overflow cases return theirs one cycle after that edge. `busy` rises one cycle after the start edge. A behavioural model in the bench counts these latencies down from the start edge. On every falling clock edge it compares all outputs, so a result that is early, late or missing shows up as a mismatch in a specific cycle. Starts given while busy and input changes while idle are checked the same way, because the model expects the outputs to stay put.

// File: rtl/div_pkg.sv
package div_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } div_state_e;

    typedef enum logic [1:0] {
        SCR_OK   = 2'd0,
        SCR_ZERO = 2'd1,
        SCR_OVF  = 2'd2
    } div_screen_e;

endpackage

// File: rtl/div_screen.sv
module div_screen #(
    parameter int N = 8
) (
    input  logic [N-1:0]         dvd_hi,
    input  logic [N-1:0]         dvs,
    output div_pkg::div_screen_e verdict
);
    import div_pkg::*;

    always_comb begin
        if (dvs == '0)
            verdict = SCR_ZERO;
        else if (dvd_hi >= dvs)
            verdict = SCR_OVF;
        else
            verdict = SCR_OK;
    end
endmodule

// File: rtl/div_step.sv
module div_step #(
    parameter int N = 8
) (
    input  logic         carry_in,
    input  logic [N-1:0] hi_in,
    input  logic [N-1:0] lo_in,
    input  logic [N-1:0] dvs,
    output logic         carry_out,
    output logic [N-1:0] hi_out,
    output logic [N-1:0] lo_out
);
    localparam int AW = N + 2;

    logic [AW-1:0] diff;
    logic          neg;
    logic [N-1:0]  kept;

    always_comb begin
        diff = {1'b0, carry_in, hi_in} - {2'b00, dvs};
        neg  = diff[AW-1];
        kept = neg ? hi_in : diff[N-1:0];
        carry_out = kept[N-1];
        hi_out    = {kept[N-2:0], lo_in[N-1]};
        lo_out    = {lo_in[N-2:0], ~neg};
    end
endmodule

// File: rtl/div_ctrl.sv
module div_ctrl #(
    parameter int N = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                screened_ok,
    output logic                accept,
    output logic                load,
    output logic                step_en,
    output logic                fin,
    output logic                busy
);
    import div_pkg::*;

    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    div_state_e     state_q;
    logic [CW-1:0]  cnt_q;

    assign accept  = start && (state_q == ST_IDLE);
    assign load    = accept && screened_ok;
    assign step_en = (state_q == ST_RUN);
    assign fin     = (state_q == ST_FIX);
    assign busy    = (state_q != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (load) state_q <= ST_RUN;
                end
                ST_RUN: begin
                    if (cnt_q == LAST) begin
                        state_q <= ST_FIX;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_FIX:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/div_restoring.sv
module div_restoring #(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [2*N-1:0] dividend,
    input  logic [N-1:0]   divisor,
    output logic           busy,
    output logic           done,
    output logic [N-1:0]   quotient,
    output logic [N-1:0]   remainder,
    output logic           div_by_zero,
    output logic           overflow
);
    import div_pkg::*;

    div_screen_e  verdict;
    logic         accept, load, step_en, fin;

    logic         carry_q;
    logic [N-1:0] hi_q, lo_q, dvs_q;
    logic         carry_d;
    logic [N-1:0] hi_d, lo_d;

    div_screen #(.N(N)) u_screen (
        .dvd_hi (dividend[2*N-1:N]),
        .dvs    (divisor),
        .verdict(verdict)
    );

    div_ctrl #(.N(N)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .screened_ok(verdict == SCR_OK),
        .accept     (accept),
        .load       (load),
        .step_en    (step_en),
        .fin        (fin),
        .busy       (busy)
    );

    div_step #(.N(N)) u_step (
        .carry_in (carry_q),
        .hi_in    (hi_q),
        .lo_in    (lo_q),
        .dvs      (dvs_q),
        .carry_out(carry_d),
        .hi_out   (hi_d),
        .lo_out   (lo_d)
    );

    // Working register: load with the dividend already shifted left once.
    always_ff @(posedge clk) begin
        if (rst) begin
            carry_q <= 1'b0;
            hi_q    <= '0;
            lo_q    <= '0;
            dvs_q   <= '0;
        end else if (load) begin
            {carry_q, hi_q, lo_q} <= {dividend, 1'b0};
            dvs_q <= divisor;
        end else if (step_en) begin
            carry_q <= carry_d;
            hi_q    <= hi_d;
            lo_q    <= lo_d;
        end
    end

    // Result registers: written only on completion.
    always_ff @(posedge clk) begin
        if (rst) begin
            done        <= 1'b0;
            quotient    <= '0;
            remainder   <= '0;
            div_by_zero <= 1'b0;
            overflow    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (fin) begin
                done        <= 1'b1;
                quotient    <= lo_q;
                remainder   <= {carry_q, hi_q[N-1:1]};
                div_by_zero <= 1'b0;
                overflow    <= 1'b0;
            end else if (accept && verdict != SCR_OK) begin
                done        <= 1'b1;
                quotient    <= '1;
                remainder   <= dividend[N-1:0];
                div_by_zero <= (verdict == SCR_ZERO);
                overflow    <= (verdict == SCR_OVF);
            end
        end
    end
endmodule

// File: rtl/div_restoring_chk.sv
module div_restoring_chk #(
    parameter int N = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic [2*N-1:0] dividend,
    input logic [N-1:0]   divisor,
    input logic           busy,
    input logic           done,
    input logic [N-1:0]   quotient,
    input logic [N-1:0]   remainder,
    input logic           div_by_zero,
    input logic           overflow
);
    localparam int BW = $clog2(N + 2) + 1;

    logic [2*N-1:0] cap_dvd;
    logic [N-1:0]   cap_dvs;
    logic [BW-1:0]  bcnt;
    logic [2*N-1:0] recon;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_dvd <= '0;
            cap_dvs <= '0;
            bcnt    <= '0;
        end else begin
            if (start && !busy) begin
                cap_dvd <= dividend;
                cap_dvs <= divisor;
            end
            bcnt <= busy ? bcnt + 1'b1 : '0;
        end
    end

    assign recon = (2*N)'(quotient) * (2*N)'(cap_dvs) + (2*N)'(remainder);

    assert_busy_len_R1: assert property (@(posedge clk) disable iff (rst)
        busy |-> (bcnt <= BW'(N)));

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_fall_done_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    assert_result_R3: assert property (@(posedge clk) disable iff (rst)
        (done && !div_by_zero && !overflow) |-> (remainder < cap_dvs && recon == cap_dvd));

    assert_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (done && div_by_zero) |-> (quotient == '1 && remainder == cap_dvd[N-1:0] && !overflow));

    assert_ovf_R6: assert property (@(posedge clk) disable iff (rst)
        (done && overflow) |-> (quotient == '1 && cap_dvd[2*N-1:N] >= cap_dvs && cap_dvs != '0));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(quotient) && $stable(remainder)
                               && $stable(div_by_zero) && $stable(overflow)));
endmodule

bind div_restoring div_restoring_chk #(.N(N)) u_chk (
    .clk(clk), .rst(rst), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient), .remainder(remainder),
    .div_by_zero(div_by_zero), .overflow(overflow)
);

// File: tb/tb_div_restoring.sv
module tb_div_restoring;
    localparam int N = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [2*N-1:0] dividend = '0;
    logic [N-1:0]   divisor = '0;
    logic           busy, done, div_by_zero, overflow;
    logic [N-1:0]   quotient, remainder;

    int    errors = 0;
    int    checks = 0;
    int    cycles = 0;
    string phase  = "R10";

    // behavioural reference state
    bit     m_busy, m_done, m_dz, m_ov;
    int     m_cnt;
    longint m_q, m_r, p_q, p_r;

    div_restoring #(.N(N)) dut (
        .clk(clk), .rst(rst), .start(start), .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done), .quotient(quotient), .remainder(remainder),
        .div_by_zero(div_by_zero), .overflow(overflow)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", phase, what, act, exp, cycles);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_busy = 0; m_done = 0; m_dz = 0; m_ov = 0; m_cnt = 0; m_q = 0; m_r = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_busy = 0; m_done = 1; m_q = p_q; m_r = p_r; m_dz = 0; m_ov = 0;
                end
            end else if (start) begin
                if (divisor == 0) begin
                    m_done = 1; m_q = (1 << N) - 1; m_r = dividend % (1 << N); m_dz = 1; m_ov = 0;
                end else if ((dividend >> N) >= divisor) begin
                    m_done = 1; m_q = (1 << N) - 1; m_r = dividend % (1 << N); m_dz = 0; m_ov = 1;
                end else begin
                    m_busy = 1; m_cnt = N + 1;
                    p_q = longint'(dividend) / longint'(divisor);
                    p_r = longint'(dividend) % longint'(divisor);
                end
            end
        end
    end

    always @(negedge clk) begin
        check(busy == m_busy, "busy", busy, m_busy);
        check(done == m_done, "done", done, m_done);
        check(quotient == m_q, "quotient", quotient, m_q);
        check(remainder == m_r, "remainder", remainder, m_r);
        check(div_by_zero == m_dz, "div_by_zero", div_by_zero, m_dz);
        check(overflow == m_ov, "overflow", overflow, m_ov);
    end

    task automatic op(input longint dvd, input longint dvs, input string ph);
        phase = ph;
        @(negedge clk);
        dividend = (2*N)'(dvd);
        divisor  = N'(dvs);
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (N + 3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        phase = "R10";
        repeat (2) @(negedge clk);

        op(250, 10, "R4");
        op(100, 7, "R3");
        op(0, 5, "R3");
        op(255, 1, "R1");
        op(16'h00FF, 16'h10, "R2");
        op(16'hFEFF, 8'hFF, "R11");
        op(16'h7FFF, 8'h80, "R11");
        op(1234, 0, "R5");
        op(16'h0A00, 8'h0A, "R6");
        op(16'hFFFF, 8'h01, "R6");
        op(300, 7, "R7");

        // R8: a second start while busy must be ignored
        phase = "R8";
        @(negedge clk);
        dividend = 16'd5000; divisor = 8'd77; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        dividend = 16'd9; divisor = 8'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (N + 2) @(negedge clk);

        // R9: inputs wander while idle, no start
        phase = "R9";
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            dividend = 16'($urandom);
            divisor  = 8'($urandom);
        end

        // R3 sweep over many operands
        for (int i = 0; i < 200; i++) begin
            longint a = longint'($urandom_range(65535));
            longint b = longint'($urandom_range(255));
            if (i % 4 != 0 && b != 0) a = a % (b << N);
            op(a, b, "R3");
        end

        phase = "R10";
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule